// File: doc/BRIEF.md
# CAN Transmit Priority Selector

This block decides which message buffer a CAN controller sends next. Each of the buffers presents three things: a ready flag, a flag saying that it is set up for transmission, and a 4-bit priority code. A buffer takes part only when both flags are high. The block sorts the candidates by a combined key: the priority code is the upper part and the buffer index is the lower part. No two buffers can share a key, so the order is strict. With 15 buffers and 16 codes this gives 240 distinct ranks. Setting a buffer's code to the smallest or largest value moves it to the top or bottom of the order.

The winner is held in a register, so it appears one clock after the inputs it was computed from. When the frame engine accepts the offered buffer, it pulses a start input. From then on the winning index is frozen, and input changes cannot move it while the frame is on the wire. A pulse on the completion input or on the lost-arbitration input ends the freeze, and the same clock edge loads a fresh result. The raw reset is asynchronous and active low. It is released to the logic through a two-stage synchronizer.

Top module: `can_tx_prio_sel`

## Requirements
- R1: A buffer is a candidate only when its ready bit and its transmit-mode bit are both 1. Buffers that are not candidates never appear on `sel_idx_o`.
- R2: Among candidates, the one with the numerically smallest priority code wins. Code 0 is the most urgent.
- R3: Among candidates with equal codes, the one with the smaller buffer index wins.
- R4: A buffer with code 0 beats every other candidate except a lower-index buffer that also has code 0. The highest-index buffer with code 15 wins only when it is the sole candidate.
- R5: When no buffer is a candidate, `sel_valid_o` is 0.
- R6: While unlocked, the outputs show the selection computed from the inputs sampled at the previous rising clock edge. They do not change between edges.
- R7: A `tx_start_i` high at a rising edge, while `sel_valid_o` is 1 and the block is unlocked, sets `sel_locked_o` at that edge. `sel_idx_o` and `sel_valid_o` keep their values.
- R8: While locked, changes to ready flags, mode bits, priority codes and further `tx_start_i` pulses do not change `sel_idx_o` or `sel_valid_o`.
- R9: A `tx_done_i` or `tx_lost_i` high at a rising edge while locked clears `sel_locked_o` at that edge. The same edge loads a fresh selection from the current inputs.
- R10: A `tx_start_i` while `sel_valid_o` is 0 is ignored, and the block stays unlocked.
- R11: While `rst_ni` is low, `sel_valid_o` and `sel_locked_o` are 0. After `rst_ni` rises, the first selection is loaded at the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| buf_ready_i | input | 15 | Per-buffer ready flag, bit n for buffer n |
| buf_is_tx_i | input | 15 | Per-buffer transmit-mode flag, bit n for buffer n |
| buf_prio_i | input | 60 | Priority codes, buffer n in bits [4n+3:4n] |
| tx_start_i | input | 1 | Frame engine accepted the offered buffer |
| tx_done_i | input | 1 | Frame finished, release the lock |
| tx_lost_i | input | 1 | Arbitration lost, release the lock |
| sel_valid_o | output | 1 | A candidate was found |
| sel_idx_o | output | 4 | Index of the winning buffer |
| sel_locked_o | output | 1 | Selection is frozen for an ongoing frame |

## Verification
A wrong comparison inside the selection tree shows up at the ports on the clock after the input pattern that triggers it. Because of this, the bench sweeps every buffer at every code, every pair of buffers, and a long run of mixed patterns, and checks the output one edge after each pattern. A lock register stuck in the wrong state shows one edge after a start or release pulse: the index either follows the inputs when it should be frozen, or stays frozen when it should be released. The bench therefore changes the inputs during the lock and checks every cycle of the hold.

// File: rtl/can_txsel_pkg.sv
package can_txsel_pkg;

  typedef enum logic {
    LK_OPEN = 1'b0,
    LK_HELD = 1'b1
  } lock_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/txsel_rst_sync.sv
module txsel_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];

  // R11: internal reset can only be released once the raw reset is high
  p_sync_release_r11: assert property (@(posedge clk) $rose(rst_sync_no) |-> rst_ni)
    else $error("sync reset released while raw reset low");

endmodule

// File: rtl/txsel_tree.sv
module txsel_tree #(
  parameter int NUM_BUF = 15,
  parameter int PRIO_W  = 4,
  parameter int IDX_W   = 4
) (
  input  logic [NUM_BUF-1:0]        elig_i,
  input  logic [NUM_BUF*PRIO_W-1:0] prio_i,
  output logic                      win_vld_o,
  output logic [PRIO_W+IDX_W-1:0]   win_key_o
);

  localparam int KW     = PRIO_W + IDX_W;
  localparam int LV     = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1;
  localparam int LEAVES = 1 << LV;

  function automatic logic [KW:0] pick(input logic [KW:0] a, input logic [KW:0] b);
    if (a[KW] && (!b[KW] || (a[KW-1:0] < b[KW-1:0]))) return a;
    else                                               return b;
  endfunction

  for (genvar lv = 0; lv <= LV; lv++) begin : g_lvl
    localparam int W = LEAVES >> lv;
    logic [KW:0] v [W];
    if (lv == 0) begin : g_leaf
      for (genvar l = 0; l < W; l++) begin : g_l
        if (l < NUM_BUF) begin : g_real
          assign v[l] = {elig_i[l], prio_i[l*PRIO_W +: PRIO_W], IDX_W'(l)};
        end else begin : g_pad
          assign v[l] = '0;
        end
      end
    end else begin : g_node
      for (genvar n = 0; n < W; n++) begin : g_n
        assign v[n] = pick(g_lvl[lv-1].v[2*n], g_lvl[lv-1].v[2*n+1]);
      end
    end
  end

  assign win_vld_o = g_lvl[LV].v[0][KW];
  assign win_key_o = g_lvl[LV].v[0][KW-1:0];

endmodule

// File: rtl/txsel_lock.sv
module txsel_lock
  import can_txsel_pkg::*;
(
  input  logic clk,
  input  logic rst_ni,
  input  logic sel_valid_i,
  input  logic tx_start_i,
  input  logic tx_done_i,
  input  logic tx_lost_i,
  output logic locked_o,
  output logic load_en_o
);

  lock_e state_q, state_d;
  logic  start_acc;
  logic  release_ev;

  always_comb begin
    start_acc  = (state_q == LK_OPEN) && tx_start_i && sel_valid_i;
    release_ev = (state_q == LK_HELD) && (tx_done_i || tx_lost_i);
    state_d    = state_q;
    if (start_acc)       state_d = LK_HELD;
    else if (release_ev) state_d = LK_OPEN;
    load_en_o  = ((state_q == LK_OPEN) && !start_acc) || release_ev;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) state_q <= LK_OPEN;
    else         state_q <= state_d;
  end

  assign locked_o = (state_q == LK_HELD);

  p_start_locks_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (!locked_o && tx_start_i && sel_valid_i) |=> locked_o)
    else $error("start did not lock");

  p_release_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (locked_o && (tx_done_i || tx_lost_i)) |=> !locked_o)
    else $error("release did not unlock");

  p_start_invalid_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (!locked_o && !sel_valid_i) |=> !locked_o)
    else $error("locked without a valid selection");

endmodule

// File: rtl/can_tx_prio_sel.sv
module can_tx_prio_sel #(
  parameter int NUM_BUF = 15,
  parameter int PRIO_W  = 4,
  parameter int SYNC_ST = 2
) (
  input  logic                                    clk,
  input  logic                                    rst_ni,
  input  logic [NUM_BUF-1:0]                      buf_ready_i,
  input  logic [NUM_BUF-1:0]                      buf_is_tx_i,
  input  logic [NUM_BUF*PRIO_W-1:0]               buf_prio_i,
  input  logic                                    tx_start_i,
  input  logic                                    tx_done_i,
  input  logic                                    tx_lost_i,
  output logic                                    sel_valid_o,
  output logic [can_txsel_pkg::idx_width(NUM_BUF)-1:0] sel_idx_o,
  output logic                                    sel_locked_o
);

  localparam int IDX_W = can_txsel_pkg::idx_width(NUM_BUF);
  localparam int KW    = PRIO_W + IDX_W;

  logic               rst_n;
  logic [NUM_BUF-1:0] elig;
  logic               win_vld;
  logic [KW-1:0]      win_key;
  logic               load_en;
  logic               valid_q, valid_d;
  logic [IDX_W-1:0]   idx_q, idx_d;

  txsel_rst_sync #(.STAGES(SYNC_ST)) u_rst (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  assign elig = buf_ready_i & buf_is_tx_i;

  txsel_tree #(.NUM_BUF(NUM_BUF), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_tree (
    .elig_i    (elig),
    .prio_i    (buf_prio_i),
    .win_vld_o (win_vld),
    .win_key_o (win_key)
  );

  txsel_lock u_lock (
    .clk         (clk),
    .rst_ni      (rst_n),
    .sel_valid_i (valid_q),
    .tx_start_i  (tx_start_i),
    .tx_done_i   (tx_done_i),
    .tx_lost_i   (tx_lost_i),
    .locked_o    (sel_locked_o),
    .load_en_o   (load_en)
  );

  always_comb begin
    valid_d = valid_q;
    idx_d   = idx_q;
    if (load_en) begin
      valid_d = win_vld;
      idx_d   = win_key[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      valid_q <= valid_d;
      idx_q   <= idx_d;
    end
  end

  assign sel_valid_o = valid_q;
  assign sel_idx_o   = idx_q;

  // checker logic: does any candidate hold a smaller key than the tree's winner
  logic better_exists;
  always_comb begin
    better_exists = 1'b0;
    for (int j = 0; j < NUM_BUF; j++) begin
      if (elig[j] && ({buf_prio_i[j*PRIO_W +: PRIO_W], IDX_W'(j)} < win_key))
        better_exists = 1'b1;
    end
  end

  p_min_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(win_vld && better_exists))
    else $error("winner is not the smallest key");

  p_valid_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load_en && rst_n) |-> (sel_valid_o == $past(|elig)))
    else $error("valid does not match candidates");

  p_winner_elig_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(load_en && rst_n) && sel_valid_o) |-> (($past(elig) >> sel_idx_o) & 1) != 0)
    else $error("winner was not a candidate");

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_locked_o && $past(sel_locked_o)) |-> ($stable(sel_idx_o) && $stable(sel_valid_o)))
    else $error("selection moved while locked");

  p_lock_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_locked_o) |-> sel_valid_o)
    else $error("locked without valid");

endmodule

// File: tb/sim_can_tx_prio_sel.sv
module sim_can_tx_prio_sel;

  localparam int CLK_PERIOD = 10;
  localparam int NB = 15;
  localparam int PW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [NB-1:0] ready, istx;
  logic [NB*PW-1:0] prio_flat;
  logic [PW-1:0] pr [NB];
  logic start, done, lost;
  logic vld, locked;
  logic [3:0] idx;
  int checks = 0, errors = 0;
  logic finished = 1'b0;
  logic [31:0] rng = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb for (int i = 0; i < NB; i++) prio_flat[i*PW +: PW] = pr[i];

  can_tx_prio_sel u0 (
    .clk(clk), .rst_ni(rst_n), .buf_ready_i(ready), .buf_is_tx_i(istx),
    .buf_prio_i(prio_flat), .tx_start_i(start), .tx_done_i(done), .tx_lost_i(lost),
    .sel_valid_o(vld), .sel_idx_o(idx), .sel_locked_o(locked)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] ref_sel();
    int best = -1;
    for (int i = 0; i < NB; i++)
      if (ready[i] && istx[i])
        if (best < 0 || pr[i] < pr[best]) best = i;
    return (best < 0) ? 5'd0 : {1'b1, 4'(best)};
  endfunction

  task automatic eval(input string tag);
    logic [4:0] e;
    @(posedge clk);
    #1;
    e = ref_sel();
    chk(tag, {31'd0, vld}, {31'd0, e[4]});
    if (e[4]) chk(tag, {28'd0, idx}, {28'd0, e[3:0]});
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ready = '0; istx = '0; start = 0; done = 0; lost = 0;
    for (int i = 0; i < NB; i++) pr[i] = '0;
    ready = '1; istx = '1;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset valid", {31'd0, vld}, 0);
    chk("R11 reset locked", {31'd0, locked}, 0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk("R11 held through sync", {31'd0, vld}, 0);
    eval("R11 first load");

    // R2 R3: one candidate at every code
    for (int b = 0; b < NB; b++)
      for (int p = 0; p < 16; p++) begin
        @(negedge clk);
        ready = '0; istx = '1; ready[b] = 1'b1; pr[b] = 4'(p);
        eval("R2 single");
      end

    // R2 R3: every pair with arithmetic codes
    for (int a = 0; a < NB; a++)
      for (int b = 0; b < NB; b++) begin
        if (a == b) continue;
        @(negedge clk);
        ready = '0; istx = '1; ready[a] = 1; ready[b] = 1;
        pr[a] = 4'((a * 7 + b * 3) % 16); pr[b] = 4'((b * 5 + a) % 16);
        if ((a + b) % 4 == 0) pr[b] = pr[a];
        eval("R3 pair");
      end

    // R1 mode bit excludes
    @(negedge clk);
    ready = '1; istx = '1; istx[0] = 0; istx[1] = 0;
    for (int i = 0; i < NB; i++) pr[i] = 4'd5;
    eval("R1 excluded");
    chk("R1 idx", {28'd0, idx}, 2);

    // R4 absolute high and low
    @(negedge clk);
    ready = '1; istx = '1;
    for (int i = 0; i < NB; i++) pr[i] = 4'd1;
    pr[14] = 4'd0;
    eval("R4 top");
    chk("R4 top idx", {28'd0, idx}, 14);
    @(negedge clk);
    for (int i = 0; i < NB; i++) pr[i] = 4'd15;
    ready = 15'h4000;
    eval("R4 bottom alone");
    chk("R4 bottom idx", {28'd0, idx}, 14);
    @(negedge clk);
    ready = 15'h4001;
    eval("R4 bottom loses");
    chk("R4 bottom loses idx", {28'd0, idx}, 0);

    // R5 nothing ready
    @(negedge clk);
    ready = '0;
    eval("R5 none");
    chk("R5 valid low", {31'd0, vld}, 0);
    @(negedge clk);
    ready = '1; istx = '0;
    eval("R5 none tx");

    // random patterns
    for (int k = 0; k < 800; k++) begin
      @(negedge clk);
      rng = nxt(rng); ready = rng[14:0]; istx = rng[29:15] | 15'(k[0] ? '1 : '0);
      for (int i = 0; i < NB; i++) begin rng = nxt(rng); pr[i] = rng[7:4]; end
      eval("R2 random");
    end

    // R6 registered latency
    @(negedge clk);
    ready = 15'h0008; istx = '1; pr[3] = 4'd2;
    eval("R6 base");
    @(negedge clk);
    ready = 15'h0100;
    #1;
    chk("R6 no early change", {28'd0, idx}, 3);
    eval("R6 next edge");

    // R7 R8 lock and hold
    @(negedge clk);
    ready = 15'h0003; pr[0] = 4'd1; pr[1] = 4'd4;
    eval("R7 pre");
    @(negedge clk) start = 1;
    @(posedge clk); #1;
    chk("R7 locked", {31'd0, locked}, 1);
    chk("R7 idx kept", {28'd0, idx}, 0);
    @(negedge clk) begin start = 0; ready = 15'h0002; pr[1] = 4'd0; end
    for (int c = 0; c < 4; c++) begin
      @(posedge clk); #1;
      chk("R8 hold idx", {28'd0, idx}, 0);
      chk("R8 hold valid", {31'd0, vld}, 1);
      @(negedge clk) start = (c == 1);
    end
    start = 0;
    // R9 release by done
    @(negedge clk) done = 1;
    eval("R9 done reload");
    chk("R9 done unlocked", {31'd0, locked}, 0);
    chk("R9 done idx", {28'd0, idx}, 1);
    @(negedge clk) begin done = 0; start = 1; end
    @(posedge clk); #1;
    chk("R7 relock", {31'd0, locked}, 1);
    @(negedge clk) begin start = 0; ready = '0; lost = 1; end
    eval("R9 lost reload");
    chk("R9 lost unlocked", {31'd0, locked}, 0);
    chk("R9 lost valid", {31'd0, vld}, 0);

    // R10 start with nothing valid
    @(negedge clk) begin lost = 0; start = 1; end
    @(posedge clk); #1;
    chk("R10 no lock", {31'd0, locked}, 0);
    @(negedge clk) begin start = 0; ready = 15'h0010; end
    eval("R10 follows inputs");
    chk("R10 idx", {28'd0, idx}, 4);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule